// File: doc/BRIEF.md
# Cascadable Serial Grayscale Shift-Latch

This block receives pixel intensity words over a three-wire serial link and presents them as one wide parallel word to a pulse-width controller. A serial data bit is taken in on every rising edge of the serial clock. Each bit enters the lowest position of a frame-wide shift register and all earlier bits move one place toward the top. A rising edge on the transfer strobe copies the whole shift register into a holding latch in one step. The PWM logic reads that latch, and is told of each new transfer by a one-cycle load pulse in its own clock domain.

Several devices can be chained. The top bit of the shift register leaves through a cascade output that is re-timed on the falling serial clock edge, so the next device in the chain gets half a clock period of setup margin. A host sends the frame for the farthest device first. After one frame length of clocks per device and a shared transfer strobe, every device latches its own frame. The frame holds `CHANNELS` words of `GS_BITS` bits each; by default that is 24 words of 12 bits, or 288 bits. The highest channel's top bit goes out first and channel 0's bit 0 goes out last. Neither register is given a value at reset, so the host must load a frame before the PWM outputs are enabled.

Top module: `gs_shift_latch`

## Requirements
- R1: On each rising `sclk` edge the `sin` value is stored in shift bit 0 and every shift bit i moves to bit i+1; the bit in the top position is discarded.
- R2: Channel n of `gs_data` occupies bits 12n+11 down to 12n, with the word's most significant bit at the higher index.
- R3: A frame is 288 bits long and sent most significant first: channel 23 bit 11 leads and channel 0 bit 0 trails. After exactly 288 rising edges the whole frame sits in place.
- R4: `sout` presents shift bit 287 through a stage updated on the falling `sclk` edge. Between a rising edge and the next falling edge, `sout` keeps its earlier value.
- R5: A rising `xlat` edge copies all 288 shift bits into `gs_data` at once.
- R6: Without an `xlat` rising edge, `gs_data` holds its value while new bits are shifted in.
- R7: Each rising `xlat` edge produces exactly one `load_pulse` that is high for one `clk` cycle, within `SYNC_STAGES`+2 `clk` cycles. Holding `xlat` high does not produce further pulses.
- R8: While `rst_n` is low, `load_pulse` stays low whatever `xlat` does. After release with `xlat` low, no pulse appears.
- R9: With two devices chained `sout` to `sin`, 576 bits of stream (far device's frame first) and one shared `xlat` edge leave each device holding its own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM-domain clock for the load pulse |
| rst_n | input | 1 | Active-low asynchronous reset of the pulse logic |
| sclk | input | 1 | Serial shift clock |
| sin | input | 1 | Serial data in |
| xlat | input | 1 | Transfer strobe; rising edge loads the latch |
| sout | output | 1 | Cascade data out, changes on falling `sclk` |
| gs_data | output | CHANNELS*GS_BITS | Latched frame, channel n at bits 12n+11:12n |
| load_pulse | output | 1 | One-cycle `clk`-domain strobe per transfer |

## Verification
The hardest case to reach is the half-cycle timing of the cascade output. It is only visible when `sout` is sampled in both clock phases, and it only matters once a second device depends on it. The bench therefore chains two instances and pushes 576-bit streams built from arithmetic patterns. It samples `sout` just after each rising edge and just after each falling edge. It also compares each device's latched channels with the frame meant for that device, so an off-by-one in the re-timing stage shows up as a frame shifted by one bit in the far device.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

   // Selects how the cascade output is driven from the top shift bit.
   typedef enum logic [0:0] {
      GSL_SOUT_DIRECT    = 1'b0,
      GSL_SOUT_HALF_CYCLE = 1'b1
   } gsl_sout_mode_e;

   localparam int unsigned GSL_DEF_CHANNELS = 24;
   localparam int unsigned GSL_DEF_BITS     = 12;
   localparam int unsigned GSL_DEF_SYNC     = 2;

endpackage

// File: rtl/gsl_shift_chain.sv
module gsl_shift_chain
   import gsl_pkg::*;
#(
   parameter int unsigned    WIDTH     = 288,
   parameter gsl_sout_mode_e SOUT_MODE = GSL_SOUT_HALF_CYCLE
) (
   input  logic             sclk,
   input  logic             sin,
   output logic [WIDTH-1:0] shift_q,
   output logic             sout
);

   localparam int unsigned TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("gsl_shift_chain: WIDTH must be at least 2");
   end

   // Serial entry at bit 0, movement toward the top bit.
   always_ff @(posedge sclk) begin
      shift_q <= {shift_q[TOP-1:0], sin};
   end

   if (SOUT_MODE == GSL_SOUT_HALF_CYCLE) begin : g_sout_retimed
      logic sout_q;
      // Extra stage on the opposite edge: downstream setup gains half a period.
      always_ff @(negedge sclk) begin
         sout_q <= shift_q[TOP];
      end
      assign sout = sout_q;
   end else begin : g_sout_direct
      assign sout = shift_q[TOP];
   end

endmodule

// File: rtl/gsl_xfer_latch.sv
module gsl_xfer_latch #(
   parameter int unsigned WIDTH = 288
) (
   input  logic             xlat,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (WIDTH < 1) begin : g_bad_width
      $error("gsl_xfer_latch: WIDTH must be positive");
   end

   // Whole-frame parallel copy on the transfer strobe edge.
   always_ff @(posedge xlat) begin
      dout <= din;
   end

endmodule

// File: rtl/gsl_load_sync.sv
module gsl_load_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gsl_load_sync: STAGES must be at least 2");
   end

   logic [LAST:0] sync_q;
   logic          hist_q;
   logic          pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         hist_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         sync_q  <= {sync_q[LAST-1:0], async_in};
         hist_q  <= sync_q[LAST];
         pulse_q <= sync_q[LAST] & ~hist_q;
      end
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/gs_shift_latch.sv
module gs_shift_latch
   import gsl_pkg::*;
#(
   parameter int unsigned    CHANNELS    = GSL_DEF_CHANNELS,
   parameter int unsigned    GS_BITS     = GSL_DEF_BITS,
   parameter int unsigned    SYNC_STAGES = GSL_DEF_SYNC,
   parameter gsl_sout_mode_e SOUT_MODE   = GSL_SOUT_HALF_CYCLE
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sclk,
   input  logic                          sin,
   input  logic                          xlat,
   output logic                          sout,
   output logic [CHANNELS*GS_BITS-1:0]   gs_data,
   output logic                          load_pulse
);

   localparam int unsigned FRAME_BITS = CHANNELS * GS_BITS;

   if (CHANNELS < 1) begin : g_bad_channels
      $error("gs_shift_latch: CHANNELS must be positive");
   end
   if (GS_BITS < 1) begin : g_bad_bits
      $error("gs_shift_latch: GS_BITS must be positive");
   end

   logic [FRAME_BITS-1:0] shift_q;

   gsl_shift_chain #(
      .WIDTH     (FRAME_BITS),
      .SOUT_MODE (SOUT_MODE)
   ) shift_i (
      .sclk    (sclk),
      .sin     (sin),
      .shift_q (shift_q),
      .sout    (sout)
   );

   gsl_xfer_latch #(
      .WIDTH (FRAME_BITS)
   ) latch_i (
      .xlat (xlat),
      .din  (shift_q),
      .dout (gs_data)
   );

   gsl_load_sync #(
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (xlat),
      .pulse    (load_pulse)
   );

endmodule

// File: rtl/gs_shift_latch_chk.sv
module gs_shift_latch_chk #(
   parameter int unsigned WIDTH   = 288,
   parameter bit          RETIMED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sclk,
   input logic             sin,
   input logic             xlat,
   input logic             sout,
   input logic [WIDTH-1:0] shift_q,
   input logic [WIDTH-1:0] gs_data,
   input logic             load_pulse
);

   // Counts serial edges since reset so no property looks before the first one.
   logic [1:0] edges_q;
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)               edges_q <= 2'd0;
      else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
   end

   // R1: entry bit
   p_shift_in_r1: assert property (@(posedge sclk) disable iff (!rst_n || edges_q == 2'd0)
      shift_q[0] == $past(sin));

   // R1: every bit moves up by one
   p_shift_move_r1: assert property (@(posedge sclk) disable iff (!rst_n || edges_q == 2'd0)
      shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0]));

   if (RETIMED) begin : g_sout_chk
      // R4: cascade output trails the top bit through the falling-edge stage
      p_sout_half_r4: assert property (@(posedge sclk) disable iff (!rst_n || edges_q == 2'd0)
         sout == $past(shift_q[WIDTH-2]));
   end

   // R5: after a transfer edge the latch equals the shift contents
   p_latch_copy_r5: assert property (@(negedge xlat) disable iff (!rst_n)
      gs_data == shift_q);

   // R7: the load strobe is one cycle wide
   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> !load_pulse);

endmodule

bind gs_shift_latch gs_shift_latch_chk #(
   .WIDTH   (FRAME_BITS),
   .RETIMED (SOUT_MODE == gsl_pkg::GSL_SOUT_HALF_CYCLE)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .sclk       (sclk),
   .sin        (sin),
   .xlat       (xlat),
   .sout       (sout),
   .shift_q    (shift_q),
   .gs_data    (gs_data),
   .load_pulse (load_pulse)
);

// File: tb/gs_shift_latch_tb_top.sv
`timescale 1ns/1ps
module gs_shift_latch_tb_top;

   localparam int NCH   = 24;
   localparam int NB    = 12;
   localparam int FB    = NCH * NB;
   localparam int SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic sin = 1'b0;
   logic xlat = 1'b0;
   logic sout_a, sout_b;
   logic [FB-1:0] data_a, data_b;
   logic pulse_a, pulse_b;

   always #2.5 clk = ~clk;

   // Device nearest the host
   gs_shift_latch dut_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .xlat(xlat),
      .sout(sout_a), .gs_data(data_a), .load_pulse(pulse_a));

   // Second device in the chain
   gs_shift_latch dut_far_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sout_a), .xlat(xlat),
      .sout(sout_b), .gs_data(data_b), .load_pulse(pulse_b));

   int n_chk = 0;
   int n_bad = 0;
   bit reported = 1'b0;

   logic stream [1:2*FB];
   logic s_hi   [1:2*FB];
   logic s_lo   [1:2*FB];

   task automatic chk(input string req, input logic [FB-1:0] act, input logic [FB-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   function automatic logic [NB-1:0] gs_val(input int pat, input int dev, input int ch);
      logic [NB-1:0] v;
      case (pat)
         0: v = '0;
         1: v = '1;
         2: v = NB'((ch * 171 + dev * 965) & 4095);
         3: v = NB'((12'h001 << (ch % NB)) ^ 12'(dev + 1));
         default: v = NB'(((ch + 1) * (dev + 7) * 37) & 4095);
      endcase
      return v;
   endfunction

   function automatic logic [FB-1:0] build_frame(input int pat, input int dev);
      logic [FB-1:0] f;
      for (int ch = 0; ch < NCH; ch++) f[ch*NB +: NB] = gs_val(pat, dev, ch);
      return f;
   endfunction

   // One serial bit; records sout during the high phase and after the falling edge.
   task automatic shift_bit(input logic b, input int idx);
      sin = b;
      #10 sclk = 1'b1;
      #5  s_hi[idx] = sout_a;
      #15 sclk = 1'b0;
      #5  s_lo[idx] = sout_a;
      #5;
   endtask

   // Transfer strobe with load-pulse measurement (R7).
   task automatic do_xlat();
      int pulses = 0;
      int first = -1;
      #10 xlat = 1'b1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (pulse_a) begin
            pulses++;
            if (first < 0) first = c;
         end
      end
      xlat = 1'b0;
      for (int c = 12; c < 18; c++) begin
         @(negedge clk);
         if (pulse_a) pulses++;
      end
      chk("R7 pulse count", FB'(pulses), FB'(1));
      chk("R7 pulse latency", FB'((first >= 0 && first <= SYNC + 1) ? 1 : 0), FB'(1));
      #10;
   endtask

   task automatic push_pair(input int pat, input bit check_sout);
      logic [FB-1:0] f_near, f_far;
      f_near = build_frame(pat, 0);
      f_far  = build_frame(pat, 1);
      for (int k = 1; k <= FB; k++)        stream[k] = f_far[FB-k];
      for (int k = FB + 1; k <= 2*FB; k++) stream[k] = f_near[2*FB-k];
      for (int k = 1; k <= 2*FB; k++) shift_bit(stream[k], k);
      if (check_sout) begin
         for (int k = FB + 1; k <= 2*FB; k++) begin
            chk("R4 sout high phase", FB'(s_hi[k]), FB'(stream[k-FB]));
            chk("R4 sout low phase",  FB'(s_lo[k]), FB'(stream[k-FB+1]));
         end
      end
      do_xlat();
      for (int ch = 0; ch < NCH; ch++) begin
         chk("R2 near channel", FB'(data_a[ch*NB +: NB]), FB'(gs_val(pat, 0, ch)));
         chk("R9 far channel",  FB'(data_b[ch*NB +: NB]), FB'(gs_val(pat, 1, ch)));
      end
      chk("R3 near frame", data_a, f_near);
      chk("R5 far frame",  data_b, f_far);
   endtask

   initial begin
      logic [FB-1:0] held_a, held_b;
      // R8: reset holds the strobe low even with xlat activity
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         xlat = (c == 2) ? 1'b1 : ((c == 4) ? 1'b0 : xlat);
         chk("R8 pulse in reset", FB'(pulse_a), FB'(0));
      end
      xlat = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk("R8 no pulse after release", FB'(pulse_a), FB'(0));
      end

      push_pair(2, 1'b1);
      push_pair(0, 1'b0);
      push_pair(1, 1'b0);
      push_pair(3, 1'b0);
      push_pair(4, 1'b1);

      // R6: shifting without a transfer leaves the latches alone
      held_a = data_a;
      held_b = data_b;
      for (int k = 1; k <= 100; k++) shift_bit(k[0] ^ k[3], k);
      chk("R6 near hold", data_a, held_a);
      chk("R6 far hold",  data_b, held_b);

      // R1: a short burst lands in the low bits, older bits move up by 5
      push_pair(2, 1'b0);
      held_a = data_a;
      shift_bit(1'b1, 1);
      shift_bit(1'b0, 2);
      shift_bit(1'b1, 3);
      shift_bit(1'b1, 4);
      shift_bit(1'b0, 5);
      do_xlat();
      chk("R1 low bits", FB'(data_a[4:0]), FB'(5'b10110));
      chk("R1 moved bits", {data_a[FB-1:5], 5'b0}, {held_a[FB-6:0], 5'b0});

      report();
   end

   initial begin
      #900000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
   end

endmodule